// File: doc/BRIEF.md
# Payload Lane Packer for a 64-bit Transmit Path

The block sits between a producer of 32-bit payload words and a 64-bit transmit data bus of a transaction-layer packet engine. For each packet it takes a 128-bit descriptor that holds the packet header. From the descriptor it reads whether the packet carries data, the payload length in DWORDs, and address bit 2. The place of address bit 2 in the descriptor depends on the header format: a 4-DWORD header carries a 64-bit address, and a 3-DWORD header carries a 32-bit address.

Payload words arrive one per handshake. They leave in pairs on the 64-bit bus. Each word goes into the lane given by its QWORD-aligned address, in little-endian order. A word whose address bit 2 is clear goes into the low half, and a word whose bit 2 is set goes into the high half. The first beat may therefore carry one word in the high half only, and the last beat may carry one word in the low half only. Each beat carries a two-bit lane-enable mask. The final beat is marked. The number of beats always equals what the length and alignment imply, because a wrong count would hang the downstream engine.

Top module: `qw_lane_packer`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are 0 and `desc_ready` is 1.
- R2: Descriptor bit 125 picks the source of address bit 2. When bit 125 is 1 (4-DWORD header), the source is descriptor bit 2. When bit 125 is 0 (3-DWORD header), the source is descriptor bit 34.
- R3: When address bit 2 is 0, payload word 2k is driven on `out_data[31:0]` and word 2k+1 on `out_data[63:32]` of beat k.
- R4: When address bit 2 is 1, the first beat carries word 0 on `out_data[63:32]`, with `out_data[31:0]` driven to 0. After that, beat k carries word 2k-1 low and word 2k high.
- R5: A data packet produces exactly ceil((N + a) / 2) beats. Here a is address bit 2 and N is the length field in descriptor bits [105:96], where a value of 0 means 1024 words.
- R6: `out_dwen` bit 0 marks the low lane and bit 1 the high lane. The mask is 2'b11 on a full beat, 2'b10 on a first beat that holds only a high word, and 2'b01 on a last beat that holds only a low word. A lane that is not enabled is driven to 0.
- R7: `out_last` is 1 on the final beat of a packet and on no other beat.
- R8: A descriptor with bit 126 equal to 0 carries no data. It is accepted in one cycle, produces no beats and takes no input words, and `desc_ready` stays 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_dwen` and `out_last` hold their values and `in_ready` is 0.
- R10: After a data descriptor is accepted, `desc_ready` is 0 until the cycle after the final beat has been transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Packer can take a descriptor |
| desc | input | 128 | Packet header descriptor |
| in_valid | input | 1 | Payload word offered |
| in_ready | output | 1 | Payload word taken this cycle |
| in_data | input | 32 | Payload word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink takes the beat |
| out_data | output | 64 | Lane-aligned payload beat |
| out_dwen | output | 2 | Lane enables: bit 0 low, bit 1 high |
| out_last | output | 1 | Final beat of the packet |

## Verification
A wrong lane pointer shows on the first beat. The bench sees the word in the wrong half, or a wrong `out_dwen`, when that beat is transferred. A remaining-word count that is off by one shows at the end of the packet: `out_last` comes one beat early or late, and the number of beats differs from the computed count. A stuck busy flag shows one cycle after the final beat, because `desc_ready` then stays low and the next packet never starts.

// File: rtl/qwp_pkg.sv
package qwp_pkg;
   typedef enum logic {
      LANE_LO = 1'b0,
      LANE_HI = 1'b1
   } qwp_lane_e;

   localparam int unsigned QWP_DESC_W = 128;
endpackage

// File: rtl/qwp_desc_decode.sv
module qwp_desc_decode #(
   parameter int unsigned DESC_W   = 128,
   parameter int unsigned LEN_W    = 10,
   parameter int unsigned LEN_LSB  = 96,
   parameter int unsigned FMT4_BIT = 125,
   parameter int unsigned DATA_BIT = 126,
   parameter int unsigned A64_POS  = 2,
   parameter int unsigned A32_POS  = 34,
   localparam int unsigned CW      = LEN_W + 1
) (
   input  logic [DESC_W-1:0] desc,
   output logic              has_data,
   output qwp_pkg::qwp_lane_e first_lane,
   output logic [CW-1:0]     n_words,
   output logic [CW-1:0]     n_beats
);
   localparam int unsigned SW = LEN_W + 2;

   logic [LEN_W-1:0] len_field;
   logic             addr_b2;
   logic [SW-1:0]    sum;

   assign len_field = desc[LEN_LSB +: LEN_W];
   assign has_data  = desc[DATA_BIT];
   // the header format decides which address word carries bit 2
   assign addr_b2   = desc[FMT4_BIT] ? desc[A64_POS] : desc[A32_POS];
   assign first_lane = addr_b2 ? qwp_pkg::LANE_HI : qwp_pkg::LANE_LO;

   always_comb begin
      if (len_field == '0) begin
         n_words = CW'(1) << LEN_W;
      end else begin
         n_words = {1'b0, len_field};
      end
   end

   assign sum     = SW'(n_words) + SW'(addr_b2) + SW'(1);
   assign n_beats = sum[SW-1:1];
endmodule

// File: rtl/qwp_beat_count.sv
module qwp_beat_count #(
   parameter int unsigned CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic [CW-1:0] left
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left <= '0;
      end else if (load) begin
         left <= load_val;
      end else if (dec) begin
         left <= left - CW'(1);
      end
   end

   p_no_underflow_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      dec && !load |-> left != '0)
      else $error("beat counter underflow");
endmodule

// File: rtl/qwp_lane_assembler.sv
module qwp_lane_assembler #(
   parameter int unsigned DW          = 32,
   parameter int unsigned CW          = 11,
   parameter bit          ZERO_UNUSED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  qwp_pkg::qwp_lane_e start_lane,
   input  logic [CW-1:0]     start_count,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DW-1:0]     in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [2*DW-1:0]   out_data,
   output logic [1:0]        out_dwen,
   output logic              out_last
);
   import qwp_pkg::*;

   logic [CW-1:0] rem_q;
   qwp_lane_e     lane_q;
   logic [DW-1:0] lo_q, hi_q;
   logic [1:0]    dwen_q;
   logic          last_q, ov_q;
   logic          take, emit, final_word;

   assign in_ready   = (rem_q != '0) && (!ov_q || out_ready);
   assign take       = in_valid && in_ready;
   assign emit       = ov_q && out_ready;
   assign final_word = (rem_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         lane_q <= LANE_LO;
         lo_q   <= '0;
         hi_q   <= '0;
         dwen_q <= '0;
         last_q <= 1'b0;
         ov_q   <= 1'b0;
      end else if (start) begin
         rem_q  <= start_count;
         lane_q <= start_lane;
         lo_q   <= '0;
         dwen_q <= '0;
         last_q <= 1'b0;
         ov_q   <= 1'b0;
      end else begin
         if (emit) begin
            ov_q <= 1'b0;
         end
         if (take) begin
            rem_q  <= rem_q - CW'(1);
            last_q <= final_word;
            if (lane_q == LANE_LO) begin
               // low word opens a beat and waits in the holding register
               lo_q   <= in_data;
               dwen_q <= 2'b01;
               lane_q <= LANE_HI;
               if (final_word) begin
                  ov_q <= 1'b1;
               end
            end else begin
               hi_q   <= in_data;
               dwen_q <= {1'b1, dwen_q[0]};
               lane_q <= LANE_LO;
               ov_q   <= 1'b1;
            end
         end
      end
   end

   assign out_valid = ov_q;
   assign out_dwen  = dwen_q;
   assign out_last  = last_q;

   generate
      if (ZERO_UNUSED) begin : g_mask
         assign out_data = {dwen_q[1] ? hi_q : {DW{1'b0}},
                            dwen_q[0] ? lo_q : {DW{1'b0}}};
      end else begin : g_raw
         assign out_data = {hi_q, lo_q};
      end
   endgenerate

   p_hold_stall_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                 && $stable(out_dwen) && $stable(out_last))
      else $error("beat changed under backpressure");

   p_dwen_nonzero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_dwen != 2'b00)
      else $error("valid beat without enabled lane");

   p_last_drains_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_last |-> rem_q == '0)
      else $error("last beat while words remain");
endmodule

// File: rtl/qw_lane_packer.sv
module qw_lane_packer #(
   parameter int unsigned DESC_W      = 128,
   parameter int unsigned DW          = 32,
   parameter int unsigned LEN_W       = 10,
   parameter int unsigned LEN_LSB     = 96,
   parameter int unsigned FMT4_BIT    = 125,
   parameter int unsigned DATA_BIT    = 126,
   parameter int unsigned A64_POS     = 2,
   parameter int unsigned A32_POS     = 34,
   parameter bit          ZERO_UNUSED = 1'b1,
   localparam int unsigned CW         = LEN_W + 1,
   localparam int unsigned OW         = 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [DESC_W-1:0] desc,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DW-1:0]     in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OW-1:0]     out_data,
   output logic [1:0]        out_dwen,
   output logic              out_last
);
   import qwp_pkg::*;

   generate
      if (LEN_LSB + LEN_W > DESC_W) begin : g_bad_len
         $error("length field exceeds descriptor");
      end
      if (FMT4_BIT >= DESC_W || DATA_BIT >= DESC_W ||
          A64_POS >= DESC_W || A32_POS >= DESC_W) begin : g_bad_pos
         $error("descriptor bit position out of range");
      end
      if (DW == 0 || LEN_W == 0) begin : g_bad_w
         $error("zero width");
      end
   endgenerate

   logic          has_data;
   qwp_lane_e     first_lane;
   logic [CW-1:0] n_words, n_beats, beats_left;
   logic          busy_q, accept, start, beat_xfer;

   qwp_desc_decode #(
      .DESC_W(DESC_W), .LEN_W(LEN_W), .LEN_LSB(LEN_LSB),
      .FMT4_BIT(FMT4_BIT), .DATA_BIT(DATA_BIT),
      .A64_POS(A64_POS), .A32_POS(A32_POS)
   ) i_decode (
      .desc(desc), .has_data(has_data), .first_lane(first_lane),
      .n_words(n_words), .n_beats(n_beats)
   );

   assign desc_ready = !busy_q;
   assign accept     = desc_valid && desc_ready;
   assign start      = accept && has_data;
   assign beat_xfer  = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
      end else if (beat_xfer && out_last) begin
         busy_q <= 1'b0;
      end
   end

   qwp_beat_count #(.CW(CW)) i_beats (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(n_beats),
      .dec(beat_xfer), .left(beats_left)
   );

   qwp_lane_assembler #(.DW(DW), .CW(CW), .ZERO_UNUSED(ZERO_UNUSED)) i_lanes (
      .clk(clk), .rst_n(rst_n), .start(start), .start_lane(first_lane),
      .start_count(n_words), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_dwen(out_dwen), .out_last(out_last)
   );

   p_last_on_final_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_last |-> beats_left == CW'(1))
      else $error("last flag before final counted beat");

   p_final_has_last_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && beats_left == CW'(1) |-> out_last)
      else $error("final counted beat without last flag");

   p_idle_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !out_valid && !in_ready)
      else $error("activity while idle");
endmodule

// File: tb/test_qw_lane_packer.sv
module test_qw_lane_packer;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          desc_valid = 1'b0;
   logic          desc_ready;
   logic [127:0]  desc = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [31:0]   in_data = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [63:0]   out_data;
   logic [1:0]    out_dwen;
   logic          out_last;

   int n_chk = 0;
   int n_err = 0;
   int cyc_all = 0;

   always #4 clk = ~clk;

   qw_lane_packer i_qw_lane_packer (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc(desc), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_dwen(out_dwen), .out_last(out_last)
   );

   // entry: [12] 4-DWORD header, [11] address bit 2, [10:1] length, [0] stall sink
   localparam logic [12:0] VEC [12] = '{
      {1'b1, 1'b0, 10'd5, 1'b0}, {1'b1, 1'b1, 10'd5, 1'b0},
      {1'b0, 1'b0, 10'd5, 1'b1}, {1'b0, 1'b1, 10'd5, 1'b1},
      {1'b1, 1'b0, 10'd1, 1'b0}, {1'b1, 1'b1, 10'd1, 1'b0},
      {1'b0, 1'b0, 10'd2, 1'b1}, {1'b0, 1'b1, 10'd2, 1'b0},
      {1'b1, 1'b1, 10'd4, 1'b1}, {1'b0, 1'b0, 10'd7, 1'b0},
      {1'b1, 1'b0, 10'd0, 1'b0}, {1'b0, 1'b1, 10'd0, 1'b1}
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] word_val(input int v, input int k);
      return {v[7:0], 8'hA5, k[15:0]};
   endfunction

   function automatic logic [127:0] make_desc(input bit fmt4, input bit a2,
                                               input logic [9:0] len, input bit data);
      logic [127:0] d;
      d = '0;
      d[126] = data;
      d[125] = fmt4;
      d[105:96] = len;
      if (fmt4) begin
         d[2] = a2;  d[34] = ~a2;
      end else begin
         d[34] = a2; d[2] = ~a2;
      end
      return d;
   endfunction

   task automatic send_desc(input logic [127:0] d);
      @(negedge clk);
      desc = d;
      desc_valid = 1'b1;
      #1;
      while (!desc_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      desc_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc_all++;
      if (cyc_all > 150000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc_all);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      in_valid = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b0, "R1 in_ready in reset", 64'(in_ready), 64'd0);
      chk(desc_ready == 1'b1, "R1 desc_ready in reset", 64'(desc_ready), 64'd1);
      in_valid = 1'b0;
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R5 R6 R7 R9 R10
      for (int v = 0; v < 12; v++) begin
         bit   fmt4, a2, stall, done, prev_stall, first;
         int   n, nb, k, b, cyc;
         logic [63:0] p_data;
         logic [1:0]  p_dwen;
         logic        p_last;
         fmt4  = VEC[v][12];
         a2    = VEC[v][11];
         stall = VEC[v][0];
         n     = (VEC[v][10:1] == 10'd0) ? 1024 : int'(VEC[v][10:1]);
         nb    = (n + int'(a2) + 1) / 2;
         send_desc(make_desc(fmt4, a2, VEC[v][10:1], 1'b1));
         k = 0; b = 0; cyc = 0; done = 0; prev_stall = 0; first = 1;
         p_data = '0; p_dwen = '0; p_last = 1'b0;
         while (!done) begin
            @(negedge clk);
            cyc++;
            out_ready = stall ? (cyc % 3 != 0) : 1'b1;
            in_valid  = (k < n);
            in_data   = word_val(v, k);
            #1;
            if (first) begin
               chk(desc_ready == 1'b0, "R10 desc_ready low in packet",
                   64'(desc_ready), 64'd0);
               first = 0;
            end
            if (prev_stall) begin
               chk(out_valid && out_data == p_data && out_dwen == p_dwen &&
                   out_last == p_last, "R9 beat held under stall",
                   out_data, p_data);
            end
            prev_stall = 0;
            if (out_valid && !out_ready) begin
               chk(in_ready == 1'b0, "R9 no input while stalled",
                   64'(in_ready), 64'd0);
               prev_stall = 1;
               p_data = out_data; p_dwen = out_dwen; p_last = out_last;
            end
            if (out_valid && out_ready) begin
               logic [63:0] e_data;
               logic [1:0]  e_dwen;
               for (int ln = 0; ln < 2; ln++) begin
                  int wi;
                  wi = 2 * b + ln - int'(a2);
                  if (wi >= 0 && wi < n) begin
                     e_dwen[ln] = 1'b1;
                     e_data[32*ln +: 32] = word_val(v, wi);
                  end else begin
                     e_dwen[ln] = 1'b0;
                     e_data[32*ln +: 32] = 32'd0;
                  end
               end
               chk(out_data == e_data, a2 ? "R4 R2 lane data" : "R3 R2 lane data",
                   out_data, e_data);
               chk(out_dwen == e_dwen, "R6 lane enables", 64'(out_dwen), 64'(e_dwen));
               chk(out_last == (b == nb - 1), "R7 last flag",
                   64'(out_last), 64'(b == nb - 1));
               b++;
               if (out_last || b > nb) done = 1;
            end
            if (in_valid && in_ready) k++;
            if (cyc > 4000) done = 1;
         end
         in_valid = 1'b0;
         chk(b == nb, "R5 beat count", 64'(b), 64'(nb));
         chk(k == n, "R5 words consumed", 64'(k), 64'(n));
         @(negedge clk);
         #1;
         chk(desc_ready == 1'b1, "R10 desc_ready back after last",
             64'(desc_ready), 64'd1);
      end

      // R8: descriptor without data
      send_desc(make_desc(1'b1, 1'b1, 10'd5, 1'b0));
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         out_ready = 1'b1;
         #1;
         chk(out_valid == 1'b0 && in_ready == 1'b0, "R8 no beats no input",
             {62'd0, out_valid, in_ready}, 64'd0);
         chk(desc_ready == 1'b1, "R8 desc_ready stays high",
             64'(desc_ready), 64'd1);
      end
      in_valid = 1'b0;

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule